// File: doc/BRIEF.md
# Nonvolatile Memory Fault Status Register Unit

This block collects status for an ECC-protected nonvolatile memory controller and keeps it where a processor can read it. Four internal paths can report a double-bit fault: an array read, an erase-verify pass, a data-compress pass, and the read of the protection and security fields during the reset sequence. Each report sets a double-fault flag and an access-error flag. The first fault also stores the block address and the stored parity bits in holding registers. Those registers keep the first fault's contents until software clears the flags.

A fail flag records a failed erase verify or a double-bit fault from any path other than the reset sequence. A blank flag holds the outcome of the last erase verify. An interrupt request follows the double-fault flag when software has enabled it. A seven-bit command register accepts writes only while a command write sequence is open. During a faulty array read a combinational data-invalid signal goes high, so the raw, uncorrected word can be discarded. Software reaches everything through a small register bus with combinational read data.

Top module: `nvm_fault_status`

## Requirements
- R1: A cycle with `flt_valid` high sets both the double-fault flag (STAT bit 2) and the access-error flag (STAT bit 3) at the next clock edge. `flt_src` encodes the source: 0 is array read, 1 is erase verify, 2 is data compress, 3 is reset-sequence read. Every source sets both flags.
- R2: When a fault is reported while the double-fault flag is 0, `flt_addr` is captured. Its low byte reads at offset 3 and its high byte at offset 4. `flt_parity` is also captured and reads at offset 5.
- R3: While the double-fault flag is 1, further fault reports leave the captured address and parity unchanged.
- R4: A write to STAT (offset 0) with bit 3 set clears both the double-fault and the access-error flag. Writing bit 2 alone, or writing zeros, changes neither flag.
- R5: `irq` is high exactly when the double-fault flag is 1 and the interrupt enable (CTRL, offset 1, bit 0) is 1.
- R6: `rd_invalid` is high in the same cycle as `flt_valid` when `flt_src` is 0, and low otherwise.
- R7: When `ev_done` pulses, the blank flag (STAT bit 1) loads `ev_blank`. A pulse on `cmd_seq_start` clears it. Bus writes never change it.
- R8: The fail flag (STAT bit 0) sets on `ev_done` with `ev_blank` low, and on a fault from sources 0, 1 or 2, but not from source 3. Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R9: The command register at offset 2 holds bits 6..0, and bit 7 always reads 0. A write takes effect only while `cmd_seq_active` is high.
- R10: When a fault report and a clearing write to STAT fall in the same cycle, the flags end set.
- R11: Reset clears all flags, the capture registers, the interrupt enable and the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| flt_valid | input | 1 | Double-bit fault report |
| flt_src | input | 2 | Source of the fault report |
| flt_addr | input | ADDR_W | Faulting block address |
| flt_parity | input | PAR_W | Stored parity bits of the faulting word |
| rd_invalid | output | 1 | Current array read returned uncorrectable data |
| ev_done | input | 1 | Erase verify finished |
| ev_blank | input | 1 | Erase verify result, 1 for erased |
| cmd_seq_start | input | 1 | New valid command write sequence began |
| cmd_seq_active | input | 1 | Command write sequence open |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, capture register and the command register changes at the first rising edge after its stimulus. `irq` follows that same edge. `rd_invalid` and the read data are combinational, so `rd_invalid` is valid in the stimulus cycle itself. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then reads the registers at that falling edge, one rising edge after the stimulus, and checks `rd_invalid` before removing the strobe. Reset is checked immediately after assertion, because the clear is asynchronous.

// File: rtl/nvm_fault_pkg.sv
package nvm_fault_pkg;
  typedef enum logic [2:0] {
    OFS_STAT = 3'd0,
    OFS_CTRL = 3'd1,
    OFS_CMD  = 3'd2,
    OFS_CAPL = 3'd3,
    OFS_CAPH = 3'd4,
    OFS_PAR  = 3'd5
  } reg_ofs_e;

  typedef enum logic [1:0] {
    SRC_READ = 2'd0,
    SRC_EVFY = 2'd1,
    SRC_CMPR = 2'd2,
    SRC_RSEQ = 2'd3
  } flt_src_e;

  localparam int STAT_FAIL   = 0;
  localparam int STAT_BLANK  = 1;
  localparam int STAT_DBL    = 2;
  localparam int STAT_ACCERR = 3;
  localparam int BUS_W       = 8;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/nvm_fault_capture.sv
module nvm_fault_capture #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          flt_valid,
  input  logic [AW-1:0] flt_addr,
  input  logic [PW-1:0] flt_parity,
  input  logic          clr_req,
  output logic          dbl_o,
  output logic          accerr_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [PW-1:0] cap_par_o
);
  logic          dbl_q, dbl_d;
  logic          acc_q, acc_d;
  logic          cap_en;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] par_q;

  // set wins over clear; capture only on the first fault
  always_comb begin
    dbl_d = dbl_q;
    acc_d = acc_q;
    if (clr_req) begin
      dbl_d = 1'b0;
      acc_d = 1'b0;
    end
    if (flt_valid) begin
      dbl_d = 1'b1;
      acc_d = 1'b1;
    end
    cap_en = flt_valid & ~dbl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      dbl_q <= dbl_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      par_q  <= '0;
    end else if (cap_en) begin
      addr_q <= flt_addr;
      par_q  <= flt_parity;
    end
  end

  assign dbl_o      = dbl_q;
  assign accerr_o   = acc_q;
  assign cap_addr_o = addr_q;
  assign cap_par_o  = par_q;
endmodule

// File: rtl/nvm_stat_flags.sv
module nvm_stat_flags
  import nvm_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       flt_valid,
  input  logic [1:0] flt_src,
  input  logic       ev_done,
  input  logic       ev_blank,
  input  logic       cmd_seq_start,
  input  logic       fail_clr,
  output logic       fail_o,
  output logic       blank_o
);
  logic fail_q, fail_d, fail_set;
  logic blank_q, blank_d;

  always_comb begin
    fail_set = (ev_done & ~ev_blank) |
               (flt_valid & (flt_src != SRC_RSEQ));
    fail_d = fail_q;
    if (fail_clr) fail_d = 1'b0;
    if (fail_set) fail_d = 1'b1;

    blank_d = blank_q;
    if (cmd_seq_start) blank_d = 1'b0;
    if (ev_done)       blank_d = ev_blank;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      fail_q  <= fail_d;
      blank_q <= blank_d;
    end
  end

  assign fail_o  = fail_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/nvm_cmd_reg.sv
module nvm_cmd_reg #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cmd_o
);
  logic [CW-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    cmd_q <= '0;
    else if (wr_en) cmd_q <= wdata;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/nvm_fault_status.sv
module nvm_fault_status
  import nvm_fault_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAR_W  = 8,
  parameter int CMD_W  = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              flt_valid,
  input  logic [1:0]        flt_src,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [PAR_W-1:0]  flt_parity,
  output logic              rd_invalid,
  input  logic              ev_done,
  input  logic              ev_blank,
  input  logic              cmd_seq_start,
  input  logic              cmd_seq_active,
  output logic              irq
);
  localparam int ADDR_EXT_W = 2 * BUS_W;

  logic              rst_sync_n;
  logic              wr_stat, wr_ctrl, wr_cmd;
  logic              clr_dbl, clr_fail;
  logic              dbl, accerr, fail, blank;
  logic              ie_q, ie_d;
  logic [ADDR_W-1:0] cap_addr;
  logic [PAR_W-1:0]  cap_par;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_EXT_W-1:0] cap_addr_ext;
  logic              unused_wdata;

  nvm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  // bus write decode
  always_comb begin
    wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    wr_cmd   = reg_wr && (reg_addr == OFS_CMD) && cmd_seq_active;
    clr_dbl  = wr_stat && reg_wdata[STAT_ACCERR];
    clr_fail = wr_stat && reg_wdata[STAT_FAIL];
    ie_d     = wr_ctrl ? reg_wdata[0] : ie_q;
  end

  assign unused_wdata = reg_wdata[BUS_W-1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ie_q <= 1'b0;
    else             ie_q <= ie_d;
  end

  nvm_fault_capture #(.AW(ADDR_W), .PW(PAR_W)) u_cap (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_parity(flt_parity),
    .clr_req   (clr_dbl),
    .dbl_o     (dbl),
    .accerr_o  (accerr),
    .cap_addr_o(cap_addr),
    .cap_par_o (cap_par)
  );

  nvm_stat_flags u_flags (
    .clk          (clk),
    .rst_ni       (rst_sync_n),
    .flt_valid    (flt_valid),
    .flt_src      (flt_src),
    .ev_done      (ev_done),
    .ev_blank     (ev_blank),
    .cmd_seq_start(cmd_seq_start),
    .fail_clr     (clr_fail),
    .fail_o       (fail),
    .blank_o      (blank)
  );

  nvm_cmd_reg #(.CW(CMD_W)) u_cmd (
    .clk   (clk),
    .rst_ni(rst_sync_n),
    .wr_en (wr_cmd),
    .wdata (reg_wdata[CMD_W-1:0]),
    .cmd_o (cmd_q)
  );

  assign cap_addr_ext = ADDR_EXT_W'(cap_addr);

  // combinational readback
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STAT: begin
        reg_rdata[STAT_FAIL]   = fail;
        reg_rdata[STAT_BLANK]  = blank;
        reg_rdata[STAT_DBL]    = dbl;
        reg_rdata[STAT_ACCERR] = accerr;
      end
      OFS_CTRL: reg_rdata[0] = ie_q;
      OFS_CMD:  reg_rdata    = BUS_W'(cmd_q);
      OFS_CAPL: reg_rdata    = cap_addr_ext[BUS_W-1:0];
      OFS_CAPH: reg_rdata    = cap_addr_ext[ADDR_EXT_W-1:BUS_W];
      OFS_PAR:  reg_rdata    = BUS_W'(cap_par);
      default:  reg_rdata    = '0;
    endcase
  end

  assign rd_invalid = flt_valid && (flt_src == SRC_READ);
  assign irq        = dbl & ie_q;
endmodule

// File: rtl/nvm_fault_status_chk.sv
module nvm_fault_status_chk #(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flt_valid,
  input logic [1:0]    flt_src,
  input logic [AW-1:0] flt_addr,
  input logic [PW-1:0] flt_parity,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input logic          ev_done,
  input logic          ev_blank,
  input logic          cmd_seq_start,
  input logic          cmd_seq_active,
  input logic          dbl,
  input logic          accerr,
  input logic          fail,
  input logic          blank,
  input logic          ie,
  input logic          irq,
  input logic [AW-1:0] cap_addr,
  input logic [PW-1:0] cap_par,
  input logic [CW-1:0] cmd
);
  // R1
  fault_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (dbl && accerr));

  // R2
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !dbl) |=> (cap_addr == $past(flt_addr) && cap_par == $past(flt_parity)));

  // R3
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |=> ($stable(cap_addr) && $stable(cap_par)));

  // R4
  accerr_tracks_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |-> accerr);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && dbl));

  // R7
  blank_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !ev_done && !cmd_seq_start) |=> $stable(blank));

  // R8
  fail_on_not_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !ev_blank) |=> fail);

  // R8
  fail_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_src != 2'd3) |=> fail);

  // R9
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && !cmd_seq_active) |=> $stable(cmd));

  // R9
  cmd_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2) |-> (reg_rdata == 8'(cmd) && !reg_rdata[7]));
endmodule

bind nvm_fault_status nvm_fault_status_chk #(
  .AW(ADDR_W), .PW(PAR_W), .CW(CMD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .flt_valid     (flt_valid),
  .flt_src       (flt_src),
  .flt_addr      (flt_addr),
  .flt_parity    (flt_parity),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .ev_done       (ev_done),
  .ev_blank      (ev_blank),
  .cmd_seq_start (cmd_seq_start),
  .cmd_seq_active(cmd_seq_active),
  .dbl           (dbl),
  .accerr        (accerr),
  .fail          (fail),
  .blank         (blank),
  .ie            (ie_q),
  .irq           (irq),
  .cap_addr      (cap_addr),
  .cap_par       (cap_par),
  .cmd           (cmd_q)
);

// File: tb/sim_nvm_fault_status.sv
`timescale 1ns/1ps
module sim_nvm_fault_status;
  logic        clk;
  logic        rst_ni;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        flt_valid;
  logic [1:0]  flt_src;
  logic [15:0] flt_addr;
  logic [7:0]  flt_parity;
  logic        rd_invalid;
  logic        ev_done;
  logic        ev_blank;
  logic        cmd_seq_start;
  logic        cmd_seq_active;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  // {src, addr, parity, expected STAT low nibble}
  localparam logic [29:0] VEC [0:3] = '{
    {2'd0, 16'h1234, 8'hA5, 4'b1101},
    {2'd1, 16'hBEEF, 8'h3C, 4'b1101},
    {2'd2, 16'h00FF, 8'h81, 4'b1101},
    {2'd3, 16'h8001, 8'h7E, 4'b1100}
  };

  nvm_fault_status u0 (
    .clk(clk), .rst_ni(rst_ni), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
    .flt_src(flt_src), .flt_addr(flt_addr), .flt_parity(flt_parity),
    .rd_invalid(rd_invalid), .ev_done(ev_done), .ev_blank(ev_blank),
    .cmd_seq_start(cmd_seq_start), .cmd_seq_active(cmd_seq_active), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic fault(input logic [1:0] s, input logic [15:0] a, input logic [7:0] p);
    @(negedge clk);
    flt_valid = 1'b1; flt_src = s; flt_addr = a; flt_parity = p;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; reg_addr = 3'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    flt_valid = 1'b0; flt_src = 2'd0; flt_addr = 16'h0; flt_parity = 8'h0;
    ev_done = 1'b0; ev_blank = 1'b0; cmd_seq_start = 1'b0; cmd_seq_active = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 6; a++) chk_reg("R11 reset", 3'(a), 8'h00);
    check("R11 irq reset", {31'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R8 table walk over every fault source
    for (int i = 0; i < 4; i++) begin
      logic [29:0] v;
      v = VEC[i];
      wr(3'd0, 8'h09);
      fault(v[29:28], v[27:12], v[11:4]);
      chk_reg("R1/R8 stat", 3'd0, {4'h0, v[3:0]});
      chk_reg("R2 cap lo", 3'd3, v[19:12]);
      chk_reg("R2 cap hi", 3'd4, v[27:20]);
      chk_reg("R2 parity", 3'd5, v[11:4]);
    end

    // R3 first fault kept
    wr(3'd0, 8'h09);
    fault(2'd0, 16'hAAAA, 8'h11);
    fault(2'd2, 16'h5555, 8'h22);
    chk_reg("R3 cap lo", 3'd3, 8'hAA);
    chk_reg("R3 cap hi", 3'd4, 8'hAA);
    chk_reg("R3 parity", 3'd5, 8'h11);

    // R4 clear rules
    wr(3'd0, 8'h04);
    chk_reg("R4 dbl bit write ignored", 3'd0, 8'h0D);
    wr(3'd0, 8'h00);
    chk_reg("R4 zero write ignored", 3'd0, 8'h0D);
    wr(3'd0, 8'h08);
    chk_reg("R4 accerr clears both", 3'd0, 8'h01);
    wr(3'd0, 8'h01);
    chk_reg("R8 fail w1c", 3'd0, 8'h00);

    // R5 interrupt gating
    wr(3'd1, 8'h01);
    #1 check("R5 irq idle", {31'h0, irq}, 32'h0);
    fault(2'd3, 16'h0102, 8'h03);
    #1 check("R5 irq set", {31'h0, irq}, 32'h1);
    wr(3'd1, 8'h00);
    #1 check("R5 irq masked", {31'h0, irq}, 32'h0);
    wr(3'd0, 8'h09);

    // R6 data-invalid, same cycle
    @(negedge clk);
    flt_valid = 1'b1; flt_src = 2'd0; flt_addr = 16'h0F0F; flt_parity = 8'h44;
    #1 check("R6 read fault invalid", {31'h0, rd_invalid}, 32'h1);
    flt_src = 2'd2;
    #1 check("R6 compress no invalid", {31'h0, rd_invalid}, 32'h0);
    @(negedge clk);
    flt_valid = 1'b0;
    wr(3'd0, 8'h09);

    // R7 blank flag
    @(negedge clk); ev_done = 1'b1; ev_blank = 1'b1;
    @(negedge clk); ev_done = 1'b0;
    chk_reg("R7 blank set", 3'd0, 8'h02);
    wr(3'd0, 8'hFF);
    chk_reg("R7 write ignored", 3'd0, 8'h02);
    @(negedge clk); cmd_seq_start = 1'b1;
    @(negedge clk); cmd_seq_start = 1'b0;
    chk_reg("R7 seq start clears", 3'd0, 8'h00);
    @(negedge clk); ev_done = 1'b1; ev_blank = 1'b0;
    @(negedge clk); ev_done = 1'b0;
    chk_reg("R8 not erased fails", 3'd0, 8'h01);
    wr(3'd0, 8'h01);

    // R9 command register
    wr(3'd2, 8'h55);
    chk_reg("R9 locked write", 3'd2, 8'h00);
    cmd_seq_active = 1'b1;
    wr(3'd2, 8'hFF);
    chk_reg("R9 msb reads zero", 3'd2, 8'h7F);
    wr(3'd2, 8'h2A);
    chk_reg("R9 write", 3'd2, 8'h2A);
    cmd_seq_active = 1'b0;

    // R10 set beats clear
    @(negedge clk);
    flt_valid = 1'b1; flt_src = 2'd1; flt_addr = 16'hC3D4; flt_parity = 8'h99;
    reg_addr = 3'd0; reg_wdata = 8'h09; reg_wr = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0;
    chk_reg("R10 set priority", 3'd0, 8'h0D);
    chk_reg("R10 captured", 3'd4, 8'hC3);

    // R11 asynchronous reset mid-run
    wr(3'd1, 8'h01);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_reg("R11 stat cleared", 3'd0, 8'h00);
    chk_reg("R11 ctrl cleared", 3'd1, 8'h00);
    chk_reg("R11 cmd cleared", 3'd2, 8'h00);
    chk_reg("R11 cap cleared", 3'd4, 8'h00);
    check("R11 irq cleared", {31'h0, irq}, 32'h0);
    rd(3'd0, rv);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule